// File: doc/BRIEF.md
# Floating-Point Operand Unpacker

This unit turns a raw register operand into the single internal number form that a floating-point datapath works on. A type select tells it how to read the operand: as a 32-bit or 64-bit two's-complement integer, or as a single, double or quad precision value. Every input type comes out in the same shape. That shape has a sign, an unbiased signed exponent, a 128-bit mantissa with the integer one at bit 127, a sticky bit and a class code.

Integers and denormals share one leading-zero counter and left shifter, so every finite nonzero result leaves the unit normalized. Signalling NaNs are made quiet while they are unpacked. They keep a class code of their own, and the unit raises an invalid-operation flag for them. The result is registered, and it appears one clock after an input is presented with `in_valid`.

The operand is left-aligned in the 128-bit input. A 32-bit value sits in bits [127:96], a 64-bit value in bits [127:64], and a quad value fills the whole input.

Top module: `fpu_unpack`

## Requirements
- R1: When `in_valid` is high on a clock edge, the outputs take the new result and `out_valid` is high for the next cycle. When `in_valid` is low, `out_valid` goes low and all result outputs hold their values. While `rst_n` is low, every output is zero after the clock edge.
- R2: `out_sign` equals operand bit 127 for every supported type. `out_sticky` is always 0.
- R3: Type code 0 is a 32-bit integer and type code 1 is a 64-bit integer. An integer of zero gives class ZERO (code 0) with a mantissa and exponent of 0.
- R4: A nonzero integer is converted to its magnitude. Before the shift its exponent is 31 (32-bit) or 63 (64-bit), with the magnitude placed at the top of the mantissa. It is then shifted left until bit 127 is set, and the exponent drops by the shift count. The class is NUM (code 1).
- R5: Type codes 2, 3 and 4 are single, double and quad. Their exponent fields are 8, 11 and 15 bits wide, their fraction fields are 23, 52 and 112 bits wide, and their biases are 127, 1023 and 16383. A zero exponent field with a zero fraction gives class ZERO, and the sign is kept.
- R6: A zero exponent field with a nonzero fraction is a denormal. Its exponent starts at 1 minus the bias and no integer one is inserted. It is then normalized as in R4, and the class is NUM.
- R7: Any other exponent field that is not all ones gives a NUM. Its exponent is the field minus the bias, bit 127 of the mantissa is set, and the fraction sits directly below bit 127, left-aligned. No fraction bit is lost, including in quad.
- R8: An all-ones exponent field with a zero fraction gives class INF (code 2).
- R9: An all-ones exponent field with a nonzero fraction whose top bit is set gives class QNAN (code 3). The fraction is copied into bits 126 and below, bit 127 is 0, and `out_invalid` is 0.
- R10: An all-ones exponent field with a nonzero fraction whose top bit is clear gives class SNAN (code 4). Mantissa bit 126 is forced to 1, and `out_invalid` is 1.
- R11: Type codes 5 to 7 give class ZERO with `out_bad_type` high. In that case the sign, exponent, mantissa and `out_invalid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| in_type | input | 3 | Operand type code |
| in_opnd | input | 128 | Left-aligned raw operand |
| out_valid | output | 1 | Result produced from the previous cycle's operand |
| out_sign | output | 1 | Sign of the unpacked number |
| out_exp | output | 18 | Unbiased exponent, two's complement |
| out_mant | output | 128 | Mantissa, integer one at bit 127 |
| out_sticky | output | 1 | Sticky bit, always 0 after unpacking |
| out_class | output | 3 | 0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| out_invalid | output | 1 | Invalid operation (signalling NaN operand) |
| out_bad_type | output | 1 | Unsupported type code |

## Verification
The bench builds the unit with its default parameters: a 128-bit mantissa, an 18-bit exponent and the 8/11/15 exponent-field formats. These defaults allow the shifter's full range to be tested. That range includes a 112-place shift for the smallest quad denormal, a 52-place shift for the smallest double denormal, and the magnitude of the most negative 32-bit integer. With the quad fraction sitting flush under bit 127, the bench can also show that the lowest quad fraction bit survives unpacking.

// File: rtl/fpu_unpack_pkg.sv
// Shared codes for the operand unpacker: operand type select and result class.
package fpu_unpack_pkg;
    typedef enum logic [2:0] {
        TY_I32  = 3'd0,
        TY_I64  = 3'd1,
        TY_SGL  = 3'd2,
        TY_DBL  = 3'd3,
        TY_QUAD = 3'd4
    } op_type_e;

    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_NUM  = 3'd1,
        CLS_INF  = 3'd2,
        CLS_QNAN = 3'd3,
        CLS_SNAN = 3'd4
    } num_class_e;
endpackage

// File: rtl/fpu_fmt_decode.sv
// Decodes one IEEE binary format (sign excluded) into class, exponent and
// left-aligned mantissa. Assumes MANT_W > FRAC_BITS + 1 and that EXP_W can
// hold the bias plus the largest normalization shift.
module fpu_fmt_decode
    import fpu_unpack_pkg::*;
#(
    parameter int EXP_BITS  = 8,
    parameter int FRAC_BITS = 23,
    parameter int MANT_W    = 128,
    parameter int EXP_W     = 18
) (
    input  logic [EXP_BITS+FRAC_BITS-1:0] body_i,
    output num_class_e                    cls_o,
    output logic [EXP_W-1:0]              exp_o,
    output logic [MANT_W-1:0]             mant_o,
    output logic                          norm_req_o,
    output logic                          snan_o
);
    localparam int BIAS = (1 << (EXP_BITS - 1)) - 1;
    localparam int PAD  = MANT_W - 1 - FRAC_BITS;

    logic [EXP_BITS-1:0]  efield;
    logic [FRAC_BITS-1:0] ffield;
    logic                 e_zero, e_ones, f_zero;

    assign efield = body_i[EXP_BITS+FRAC_BITS-1:FRAC_BITS];
    assign ffield = body_i[FRAC_BITS-1:0];
    assign e_zero = (efield == '0);
    assign e_ones = (efield == '1);
    assign f_zero = (ffield == '0);

    // Classify the encoding and build the pre-normalization result.
    always_comb begin
        cls_o      = CLS_NUM;
        exp_o      = '0;
        mant_o     = {1'b0, ffield, {PAD{1'b0}}};
        norm_req_o = 1'b0;
        snan_o     = 1'b0;
        if (e_zero) begin
            if (f_zero) begin
                cls_o  = CLS_ZERO;
                mant_o = '0;
            end else begin
                exp_o      = EXP_W'(1) - EXP_W'(BIAS);
                norm_req_o = 1'b1;
            end
        end else if (e_ones) begin
            if (f_zero) begin
                cls_o  = CLS_INF;
                mant_o = '0;
            end else if (!ffield[FRAC_BITS-1]) begin
                cls_o                    = CLS_SNAN;
                snan_o                   = 1'b1;
                mant_o[MANT_W-2]         = 1'b1;
            end else begin
                cls_o = CLS_QNAN;
            end
        end else begin
            exp_o            = EXP_W'(efield) - EXP_W'(BIAS);
            mant_o[MANT_W-1] = 1'b1;
        end
    end
endmodule

// File: rtl/fpu_int_stage.sv
// Converts a two's-complement integer to a magnitude placed at the top of
// the mantissa, with the exponent of its top bit. Assumes MANT_W >= INT_W.
module fpu_int_stage #(
    parameter int INT_W  = 32,
    parameter int MANT_W = 128,
    parameter int EXP_W  = 18
) (
    input  logic [INT_W-1:0]  val_i,
    output logic              zero_o,
    output logic [EXP_W-1:0]  exp_o,
    output logic [MANT_W-1:0] mant_o
);
    logic [INT_W-1:0] mag;

    // Negative values become their magnitude; the minimum value maps to itself.
    always_comb mag = val_i[INT_W-1] ? (~val_i + 1'b1) : val_i;

    assign zero_o = (val_i == '0);
    assign exp_o  = EXP_W'(INT_W - 1);
    assign mant_o = {mag, {(MANT_W-INT_W){1'b0}}};
endmodule

// File: rtl/fpu_lz_norm.sv
// Leading-zero count and left shift: moves the top set bit to MANT_W-1 and
// lowers the exponent by the shift. Assumes a nonzero mantissa when used.
module fpu_lz_norm #(
    parameter int MANT_W = 128,
    parameter int EXP_W  = 18
) (
    input  logic [MANT_W-1:0] mant_i,
    input  logic [EXP_W-1:0]  exp_i,
    output logic [MANT_W-1:0] mant_o,
    output logic [EXP_W-1:0]  exp_o
);
    localparam int LZ_W = $clog2(MANT_W);

    logic [LZ_W-1:0] lz;
    logic            found;

    // Priority search for the highest set bit.
    always_comb begin
        lz    = '0;
        found = 1'b0;
        for (int i = MANT_W - 1; i >= 0; i--) begin
            if (!found && mant_i[i]) begin
                lz    = LZ_W'(MANT_W - 1 - i);
                found = 1'b1;
            end
        end
    end

    assign mant_o = mant_i << lz;
    assign exp_o  = exp_i - EXP_W'(lz);
endmodule

// File: rtl/fpu_unpack.sv
// Operand unpacker top: selects the integer or IEEE decode for the type code,
// normalizes integers and denormals through one shifter, and registers the
// result. Operands are left-aligned in OPND_W bits; assumes OPND_W == MANT_W.
module fpu_unpack
    import fpu_unpack_pkg::*;
#(
    parameter int MANT_W    = 128,
    parameter int EXP_W     = 18,
    parameter int INT_NAR_W = 32,
    parameter int INT_WID_W = 64,
    parameter int SGL_EXP   = 8,
    parameter int SGL_FRAC  = 23,
    parameter int DBL_EXP   = 11,
    parameter int DBL_FRAC  = 52,
    parameter int QUAD_EXP  = 15,
    parameter int QUAD_FRAC = 112
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        in_type,
    input  logic [MANT_W-1:0] in_opnd,
    output logic              out_valid,
    output logic              out_sign,
    output logic [EXP_W-1:0]  out_exp,
    output logic [MANT_W-1:0] out_mant,
    output logic              out_sticky,
    output logic [2:0]        out_class,
    output logic              out_invalid,
    output logic              out_bad_type
);
    localparam int N_INT = 2;
    localparam int N_FMT = 3;

    logic              int_zero [N_INT];
    logic [EXP_W-1:0]  int_exp  [N_INT];
    logic [MANT_W-1:0] int_mant [N_INT];

    num_class_e        fmt_cls  [N_FMT];
    logic [EXP_W-1:0]  fmt_exp  [N_FMT];
    logic [MANT_W-1:0] fmt_mant [N_FMT];
    logic              fmt_norm [N_FMT];
    logic              fmt_snan [N_FMT];

    // Integer front ends, narrow and wide.
    for (genvar g = 0; g < N_INT; g++) begin : g_int
        localparam int IW = (g == 0) ? INT_NAR_W : INT_WID_W;
        fpu_int_stage #(.INT_W(IW), .MANT_W(MANT_W), .EXP_W(EXP_W)) int_i (
            .val_i  (in_opnd[MANT_W-1 -: IW]),
            .zero_o (int_zero[g]),
            .exp_o  (int_exp[g]),
            .mant_o (int_mant[g])
        );
    end

    // IEEE format decoders: single, double, quad.
    for (genvar g = 0; g < N_FMT; g++) begin : g_fmt
        localparam int EB = (g == 0) ? SGL_EXP  : (g == 1) ? DBL_EXP  : QUAD_EXP;
        localparam int FB = (g == 0) ? SGL_FRAC : (g == 1) ? DBL_FRAC : QUAD_FRAC;
        fpu_fmt_decode #(.EXP_BITS(EB), .FRAC_BITS(FB), .MANT_W(MANT_W), .EXP_W(EXP_W)) dec_i (
            .body_i     (in_opnd[MANT_W-2 -: EB+FB]),
            .cls_o      (fmt_cls[g]),
            .exp_o      (fmt_exp[g]),
            .mant_o     (fmt_mant[g]),
            .norm_req_o (fmt_norm[g]),
            .snan_o     (fmt_snan[g])
        );
    end

    num_class_e        pre_cls;
    logic [EXP_W-1:0]  pre_exp;
    logic [MANT_W-1:0] pre_mant;
    logic              pre_norm, pre_snan, pre_bad, pre_sign;
    logic [EXP_W-1:0]  nrm_exp;
    logic [MANT_W-1:0] nrm_mant;

    // Select the decode path for the type code.
    always_comb begin
        pre_cls  = CLS_ZERO;
        pre_exp  = '0;
        pre_mant = '0;
        pre_norm = 1'b0;
        pre_snan = 1'b0;
        pre_bad  = 1'b0;
        pre_sign = in_opnd[MANT_W-1];
        unique case (in_type)
            TY_I32, TY_I64: begin
                if (!int_zero[in_type[0]]) begin
                    pre_cls  = CLS_NUM;
                    pre_exp  = int_exp[in_type[0]];
                    pre_mant = int_mant[in_type[0]];
                    pre_norm = 1'b1;
                end
            end
            TY_SGL, TY_DBL, TY_QUAD: begin
                pre_cls  = fmt_cls[in_type - 3'd2];
                pre_exp  = fmt_exp[in_type - 3'd2];
                pre_mant = fmt_mant[in_type - 3'd2];
                pre_norm = fmt_norm[in_type - 3'd2];
                pre_snan = fmt_snan[in_type - 3'd2];
            end
            default: begin
                pre_bad  = 1'b1;
                pre_sign = 1'b0;
            end
        endcase
    end

    fpu_lz_norm #(.MANT_W(MANT_W), .EXP_W(EXP_W)) norm_i (
        .mant_i (pre_mant),
        .exp_i  (pre_exp),
        .mant_o (nrm_mant),
        .exp_o  (nrm_exp)
    );

    // Result register: loads on in_valid, clears on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_sign     <= 1'b0;
            out_exp      <= '0;
            out_mant     <= '0;
            out_sticky   <= 1'b0;
            out_class    <= CLS_ZERO;
            out_invalid  <= 1'b0;
            out_bad_type <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_sign     <= pre_sign;
                out_exp      <= pre_norm ? nrm_exp  : pre_exp;
                out_mant     <= pre_norm ? nrm_mant : pre_mant;
                out_sticky   <= 1'b0;
                out_class    <= pre_cls;
                out_invalid  <= pre_snan;
                out_bad_type <= pre_bad;
            end
        end
    end
endmodule

// File: rtl/fpu_unpack_chk.sv
// Assertion checker for the operand unpacker, bound to every instance.
module fpu_unpack_chk
    import fpu_unpack_pkg::*;
#(
    parameter int MANT_W = 128,
    parameter int EXP_W  = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        in_type,
    input logic [MANT_W-1:0] in_opnd,
    input logic              out_valid,
    input logic              out_sign,
    input logic [EXP_W-1:0]  out_exp,
    input logic [MANT_W-1:0] out_mant,
    input logic [2:0]        out_class,
    input logic              out_invalid,
    input logic              out_bad_type
);
    // R1: a presented operand yields a valid result next cycle
    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1: outputs hold when no operand is presented
    assert_hold_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_mant) && $stable(out_class) && $stable(out_exp));

    // R4: every number class result is normalized
    assert_num_normalized_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_class == CLS_NUM |-> out_mant[MANT_W-1]);

    // R3: an integer zero gives the zero class
    assert_int_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_type == TY_I32 && in_opnd[MANT_W-1 -: 32] == '0
        |=> out_class == CLS_ZERO && out_mant == '0);

    // R10: invalid flag and signalling class go together
    assert_snan_invalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_invalid == (out_class == CLS_SNAN)));

    // R9: any NaN leaves with its quiet bit set and no integer one
    assert_nan_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_class == CLS_QNAN || out_class == CLS_SNAN)
        |-> out_mant[MANT_W-2] && !out_mant[MANT_W-1]);

    // R11: an unsupported type reports zero class and no invalid
    assert_bad_type_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_bad_type |-> out_class == CLS_ZERO && !out_invalid && !out_sign);

    // R2: the sign follows the top operand bit for supported types
    assert_sign_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_type <= 3'd4 |=> out_sign == $past(in_opnd[MANT_W-1]));
endmodule

bind fpu_unpack fpu_unpack_chk #(.MANT_W(MANT_W), .EXP_W(EXP_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_type      (in_type),
    .in_opnd      (in_opnd),
    .out_valid    (out_valid),
    .out_sign     (out_sign),
    .out_exp      (out_exp),
    .out_mant     (out_mant),
    .out_class    (out_class),
    .out_invalid  (out_invalid),
    .out_bad_type (out_bad_type)
);

// File: tb/fpu_unpack_tb_top.sv
// Directed bench for the operand unpacker.
module fpu_unpack_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [2:0]   in_type = 3'd0;
    logic [127:0] in_opnd = '0;
    logic         out_valid, out_sign, out_sticky, out_invalid, out_bad_type;
    logic [17:0]  out_exp;
    logic [127:0] out_mant;
    logic [2:0]   out_class;

    int n_checks = 0;
    int n_fails  = 0;

    localparam logic [127:0] ONE = {1'b1, 127'b0};

    always #10 clk = ~clk;

    fpu_unpack dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_type(in_type),
        .in_opnd(in_opnd), .out_valid(out_valid), .out_sign(out_sign),
        .out_exp(out_exp), .out_mant(out_mant), .out_sticky(out_sticky),
        .out_class(out_class), .out_invalid(out_invalid), .out_bad_type(out_bad_type)
    );

    task automatic check(string req, logic [2:0] cls, logic sgn, logic [17:0] ex,
                         logic [127:0] mt, logic inv, logic bad);
        n_checks++;
        if (out_class !== cls || out_sign !== sgn || out_exp !== ex || out_mant !== mt ||
            out_invalid !== inv || out_bad_type !== bad || out_sticky !== 1'b0 ||
            out_valid !== 1'b1) begin
            n_fails++;
            $display("FAIL %s: got cls=%0d s=%0b e=%0d m=%h inv=%0b bad=%0b sticky=%0b v=%0b exp cls=%0d s=%0b e=%0d m=%h inv=%0b bad=%0b",
                     req, out_class, out_sign, $signed(out_exp), out_mant, out_invalid,
                     out_bad_type, out_sticky, out_valid, cls, sgn, $signed(ex), mt, inv, bad);
        end
    endtask

    // Present one operand for one cycle; result is sampled at the following negedge.
    task automatic apply(logic [2:0] ty, logic [127:0] op);
        @(negedge clk);
        in_valid = 1'b1; in_type = ty; in_opnd = op;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        n_checks++;
        if (out_valid !== 1'b0 || out_mant !== '0 || out_class !== 3'd0 || out_exp !== '0) begin
            n_fails++;
            $display("FAIL R1 reset: got v=%0b cls=%0d m=%h exp v=0 cls=0 m=0", out_valid, out_class, out_mant);
        end
    endtask

    task automatic t_int32;
        apply(3'd0, {32'h0000_0001, 96'h0});  check("R4 int32 one", 3'd1, 1'b0, 18'd0, ONE, 1'b0, 1'b0);
        apply(3'd0, {32'hFFFF_FFF8, 96'h0});  check("R4 int32 -8", 3'd1, 1'b1, 18'd3, ONE, 1'b0, 1'b0);
        apply(3'd0, {32'h8000_0000, 96'h0});  check("R4 int32 min", 3'd1, 1'b1, 18'd31, ONE, 1'b0, 1'b0);
        apply(3'd0, {32'h0, 96'hFFFF});       check("R3 int32 zero", 3'd0, 1'b0, 18'd0, '0, 1'b0, 1'b0);
    endtask

    task automatic t_int64;
        apply(3'd1, {64'h0, 64'h5});          check("R3 int64 zero", 3'd0, 1'b0, 18'd0, '0, 1'b0, 1'b0);
        apply(3'd1, {64'h5, 64'h0});          check("R4 int64 five", 3'd1, 1'b0, 18'd2, {4'hA, 124'h0}, 1'b0, 1'b0);
    endtask

    task automatic t_single;
        apply(3'd2, {32'h3F80_0000, 96'h0});  check("R7 sgl 1.0", 3'd1, 1'b0, 18'd0, ONE, 1'b0, 1'b0);
        apply(3'd2, {32'hC020_0000, 96'h0});  check("R7 sgl -2.5", 3'd1, 1'b1, 18'd1, {4'hA, 124'h0}, 1'b0, 1'b0);
        apply(3'd2, {32'h0000_0001, 96'h0});  check("R6 sgl min denorm", 3'd1, 1'b0, -18'sd149, ONE, 1'b0, 1'b0);
        apply(3'd2, {32'h8000_0000, 96'h0});  check("R5 sgl -0", 3'd0, 1'b1, 18'd0, '0, 1'b0, 1'b0);
        apply(3'd2, {32'h7F80_0000, 96'h0});  check("R8 sgl inf", 3'd2, 1'b0, 18'd0, '0, 1'b0, 1'b0);
        apply(3'd2, {32'h7FC0_0001, 96'h0});  check("R9 sgl qnan", 3'd3, 1'b0, 18'd0, {32'h4000_0100, 96'h0}, 1'b0, 1'b0);
        apply(3'd2, {32'h7F80_0001, 96'h0});  check("R10 sgl snan", 3'd4, 1'b0, 18'd0, {32'h4000_0100, 96'h0}, 1'b1, 1'b0);
    endtask

    task automatic t_double;
        apply(3'd3, {64'h3FF8_0000_0000_0000, 64'h0}); check("R7 dbl 1.5", 3'd1, 1'b0, 18'd0, {4'hC, 124'h0}, 1'b0, 1'b0);
        apply(3'd3, {64'h7FE0_0000_0000_0000, 64'h0}); check("R7 dbl max exp", 3'd1, 1'b0, 18'd1023, ONE, 1'b0, 1'b0);
        apply(3'd3, {64'h0000_0000_0000_0001, 64'h0}); check("R6 dbl min denorm", 3'd1, 1'b0, -18'sd1074, ONE, 1'b0, 1'b0);
        apply(3'd3, {64'hFFF0_0000_0000_0000, 64'h0}); check("R8 dbl -inf", 3'd2, 1'b1, 18'd0, '0, 1'b0, 1'b0);
    endtask

    task automatic t_quad;
        apply(3'd4, {16'h3FFF, 112'h0});      check("R7 quad 1.0", 3'd1, 1'b0, 18'd0, ONE, 1'b0, 1'b0);
        apply(3'd4, {16'h3FFF, 112'h1});      check("R7 quad frac lsb", 3'd1, 1'b0, 18'd0, ONE | (128'h1 << 15), 1'b0, 1'b0);
        apply(3'd4, {16'h0000, 112'h1});      check("R6 quad min denorm", 3'd1, 1'b0, -18'sd16494, ONE, 1'b0, 1'b0);
        apply(3'd4, {16'hFFFF, 112'h1});      check("R10 quad snan", 3'd4, 1'b1, 18'd0, (128'h1 << 126) | (128'h1 << 15), 1'b1, 1'b0);
    endtask

    task automatic t_bad_type;
        apply(3'd5, {32'hFF80_0001, 96'h0});  check("R11 type 5", 3'd0, 1'b0, 18'd0, '0, 1'b0, 1'b1);
        apply(3'd7, {128{1'b1}});             check("R11 type 7", 3'd0, 1'b0, 18'd0, '0, 1'b0, 1'b1);
    endtask

    // R1: with in_valid low a new operand must not disturb the held result.
    task automatic t_hold;
        apply(3'd2, {32'h3F80_0000, 96'h0});
        @(negedge clk);
        in_type = 3'd2; in_opnd = {32'h7F80_0000, 96'h0};
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || out_class !== 3'd1 || out_mant !== ONE) begin
            n_fails++;
            $display("FAIL R1 hold: got v=%0b cls=%0d m=%h exp v=0 cls=1 m=%h", out_valid, out_class, out_mant, ONE);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_int32();
        t_int64();
        t_single();
        t_double();
        t_quad();
        t_bad_type();
        t_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL R1 watchdog: got timeout exp completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule